// File: doc/BRIEF.md
# DAC Register Front End

This block is the digital side of an on-chip 12-bit voltage converter, as seen from an 8-bit special-function-register bus of a small microcontroller. It holds a control register and two data registers, a low byte and a high nibble. From these it builds the 12-bit code that drives the converter core. It also drives plain control outputs for power-down, output enable, reference range and output pin routing. The resistor string, the output amplifier, the references and the analog pin switching are outside the block and appear here only as those control pins.

Software writes the high byte first and the low byte second. A high-byte write only stages the value. The low-byte write moves the staged nibble and the new low byte into the output code together, in a single clock edge. This means the converter never sees a half-updated code. In 8-bit mode the low byte alone sets the top eight bits of the code. A clear bit in the control register holds all data state at zero for as long as it is low.

The bus is a plain register port with a one-cycle write strobe. Every write is accepted in the cycle it is presented, so the port has no back-pressure and no ready signal. Read data is a combinational function of the address.

Top module: `dac_sfr_frontend`

## Requirements
- R1: After reset, the control register, both data registers and `dac_code` are zero. `dac_pd` is 1 and `dac_oe` is 0. Reads at every address return 00h.
- R2: Control bit 0 is the enable bit. From the edge that writes it, `dac_oe` equals the bit and `dac_pd` equals its inverse.
- R3: Control bit 2 is the range select. From the edge that writes it, `dac_ref_vdd` equals the bit: 1 selects the supply range and 0 selects the internal 2.5 V range.
- R4: Control bit 4 drives `dac_pin_alt` from the edge that writes it. Control bits 7:5 are reserved: they are never stored and always read as 0.
- R5: A write to the high data register (address FCh) leaves `dac_code` unchanged.
- R6: In 12-bit mode (control bit 3 = 0), a write of byte L to the low data register (address FBh) sets `dac_code` to {staged high nibble, L} at that same edge.
- R7: In 8-bit mode (control bit 3 = 1), a low-byte write of L sets `dac_code` to {L, 4'b0000} at that edge.
- R8: A change of control bit 3 does not alter `dac_code` by itself. The new mode applies from the next low-byte write onward.
- R9: Control bit 1 is the keep bit. At every edge where the stored keep bit is 0, the low register, the high register and `dac_code` are set to zero, and data writes in those cycles are ignored.
- R10: A read at FBh returns the last stored low byte. A read at FCh returns {4'b0000, stored high nibble}. A read at FDh returns the control register.
- R11: Only addresses FBh, FCh and FDh decode. A write elsewhere changes no state, and a read elsewhere returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | One-cycle write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Combinational read data |
| dac_code | output | 12 | Code to the converter core |
| dac_pd | output | 1 | Converter power-down |
| dac_oe | output | 1 | Output buffer enable (0 means high impedance) |
| dac_ref_vdd | output | 1 | Range select: 1 for supply, 0 for internal 2.5 V |
| dac_pin_alt | output | 1 | Selects the alternate output pin |

## Verification
The code path is tested in four ways. High-byte writes are issued alone, which separates a staging register from a direct write into the code. Ordered high-then-low pairs are issued in both modes, which shows whether the nibble and low byte are placed in the right fields. A mode flip is followed by a low write, which shows whether the mode takes effect late or early. Clear periods with writes issued inside them show whether the clear overrides the bus. Random writes to all three addresses and to addresses that do not decode, with readback at each address, check decode overlap and the handling of the reserved bits.

// File: rtl/dac_sfr_pkg.sv
package dac_sfr_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - BUS_W;

  // Control register layout: bit positions are software visible
  typedef struct packed {
    logic [2:0] rsvd;
    logic       pin_alt;    // bit 4
    logic       byte_mode;  // bit 3
    logic       ref_vdd;    // bit 2
    logic       keep;       // bit 1, 0 clears data
    logic       enable;     // bit 0
  } ctrl_t;

  localparam logic [BUS_W-1:0] CTRL_WMASK = 8'h1F;
endpackage

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
  import dac_sfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output ctrl_t            ctrl
);
  logic [BUS_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & CTRL_WMASK;
  end

  assign ctrl = ctrl_t'(ctrl_q);

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rsvd == 3'b000);
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctrl.enable == $past(wdata[0]));
endmodule

// File: rtl/dac_data_regs.sv
module dac_data_regs
  import dac_sfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] lo_q,
  output logic [HI_W-1:0]  hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!keep) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (we_lo) lo_q <= wdata;
      if (we_hi) hi_q <= wdata[HI_W-1:0];
    end
  end

  assert_clear_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> (lo_q == '0) && (hi_q == '0));
  assert_hi_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && we_hi) |=> hi_q == $past(wdata[HI_W-1:0]));
endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
  import dac_sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep,
  input  logic              byte_mode,
  input  logic              load,
  input  logic [HI_W-1:0]   hi_stage,
  input  logic [BUS_W-1:0]  lo_new,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_next;

  generate
    if (CODE_W > BUS_W) begin : g_pad
      always_comb begin
        if (byte_mode) code_next = {lo_new, {(CODE_W-BUS_W){1'b0}}};
        else           code_next = {hi_stage, lo_new};
      end
    end else begin : g_narrow
      always_comb code_next = lo_new[BUS_W-1 -: CODE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code <= '0;
    else if (!keep) code <= '0;
    else if (load)  code <= code_next;
  end

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && !load) |=> $stable(code));
  assert_load_12b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && load && !byte_mode) |=> code[BUS_W-1:0] == $past(lo_new));
  assert_load_8b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && load && byte_mode) |=> code[CODE_W-1 -: BUS_W] == $past(lo_new));
  assert_clear_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> code == '0);
endmodule

// File: rtl/dac_sfr_frontend.sv
module dac_sfr_frontend
  import dac_sfr_pkg::*;
#(
  parameter logic [7:0] LO_ADDR   = 8'hFB,
  parameter logic [7:0] HI_ADDR   = 8'hFC,
  parameter logic [7:0] CTRL_ADDR = 8'hFD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sfr_we,
  input  logic [ADDR_W-1:0]  sfr_addr,
  input  logic [BUS_W-1:0]   sfr_wdata,
  output logic [BUS_W-1:0]   sfr_rdata,
  output logic [CODE_W-1:0]  dac_code,
  output logic               dac_pd,
  output logic               dac_oe,
  output logic               dac_ref_vdd,
  output logic               dac_pin_alt
);
  ctrl_t            ctrl;
  logic             hit_lo, hit_hi, hit_ctrl;
  logic [BUS_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;

  assign hit_lo   = sfr_addr == LO_ADDR;
  assign hit_hi   = sfr_addr == HI_ADDR;
  assign hit_ctrl = sfr_addr == CTRL_ADDR;

  dac_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(sfr_we && hit_ctrl),
    .wdata(sfr_wdata), .ctrl(ctrl)
  );

  dac_data_regs u_data (
    .clk(clk), .rst_n(rst_n), .keep(ctrl.keep),
    .we_lo(sfr_we && hit_lo), .we_hi(sfr_we && hit_hi),
    .wdata(sfr_wdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  dac_code_latch u_code (
    .clk(clk), .rst_n(rst_n), .keep(ctrl.keep),
    .byte_mode(ctrl.byte_mode), .load(sfr_we && hit_lo),
    .hi_stage(hi_q), .lo_new(sfr_wdata), .code(dac_code)
  );

  always_comb begin
    if (hit_lo)        sfr_rdata = lo_q;
    else if (hit_hi)   sfr_rdata = {{(BUS_W-HI_W){1'b0}}, hi_q};
    else if (hit_ctrl) sfr_rdata = ctrl;
    else               sfr_rdata = '0;
  end

  assign dac_oe      = ctrl.enable;
  assign dac_pd      = !ctrl.enable;
  assign dac_ref_vdd = ctrl.ref_vdd;
  assign dac_pin_alt = ctrl.pin_alt;

  assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && hit_ctrl) |=> (dac_oe == $past(sfr_wdata[0])) && (dac_pd == !$past(sfr_wdata[0])));
  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && hit_ctrl) |=> dac_ref_vdd == $past(sfr_wdata[2]));
  assert_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && hit_ctrl) |=> dac_pin_alt == $past(sfr_wdata[4]));
  assert_no_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && !hit_lo && !hit_hi && !hit_ctrl && ctrl.keep) |=> $stable(dac_code));
  assert_hi_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && hit_hi && ctrl.keep) |=> $stable(dac_code));
endmodule

// File: tb/test_dac_sfr_frontend.sv
module test_dac_sfr_frontend;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic [11:0] dac_code;
  logic        dac_pd, dac_oe, dac_ref_vdd, dac_pin_alt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  m_ctrl = 8'h00;
  logic [7:0]  m_lo = 8'h00;
  logic [3:0]  m_hi = 4'h0;
  logic [11:0] m_code = 12'h000;

  always #(CLK_NS/2) clk = ~clk;

  dac_sfr_frontend i_dac_sfr_frontend (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .dac_code(dac_code),
    .dac_pd(dac_pd), .dac_oe(dac_oe), .dac_ref_vdd(dac_ref_vdd),
    .dac_pin_alt(dac_pin_alt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'hFB:   return m_lo;
      8'hFC:   return {4'h0, m_hi};
      8'hFD:   return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  // Model of one clock edge, built from the requirement list
  task automatic model_edge(input logic w, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] old_ctrl;
    old_ctrl = m_ctrl;
    if (w && a == 8'hFD) m_ctrl = d & 8'h1F;                // R4 reserved bits
    if (!old_ctrl[1]) begin                                 // R9
      m_lo = 8'h00; m_hi = 4'h0; m_code = 12'h000;
    end else if (w && a == 8'hFB) begin
      m_lo = d;
      m_code = old_ctrl[3] ? {d, 4'h0} : {m_hi, d};         // R6 / R7
    end else if (w && a == 8'hFC) begin
      m_hi = d[3:0];                                        // R5
    end
  endtask

  task automatic check_outs(input string tag);
    chk(dac_code == m_code, tag, dac_code, m_code);
    chk(dac_oe == m_ctrl[0] && dac_pd == !m_ctrl[0], "R2", {dac_pd, dac_oe}, {!m_ctrl[0], m_ctrl[0]});
    chk(dac_ref_vdd == m_ctrl[2], "R3", dac_ref_vdd, m_ctrl[2]);
    chk(dac_pin_alt == m_ctrl[4], "R4", dac_pin_alt, m_ctrl[4]);
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    sfr_we = w; sfr_addr = a; sfr_wdata = d;
    @(posedge clk);
    model_edge(w, a, d);
    #2;
    sfr_we = 1'b0;
    check_outs(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = a;
    #1;
    chk(sfr_rdata == exp_read(a), tag, sfr_rdata, exp_read(a));
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1;
    check_outs("R1");
    rd(8'hFB, "R1"); rd(8'hFC, "R1"); rd(8'hFD, "R1");

    // R2 enable, keep set, 12-bit
    step(1, 8'hFD, 8'h03, "R2");
    // R5 high write alone
    step(1, 8'hFC, 8'hA5, "R5");
    rd(8'hFC, "R10");
    // R6 low write completes code
    step(1, 8'hFB, 8'h3C, "R6");
    rd(8'hFB, "R10");
    // R8 mode flip alone keeps code
    step(1, 8'hFD, 8'h0B, "R8");
    step(0, 8'h00, 8'h00, "R8");
    // R7 8-bit mode load
    step(1, 8'hFB, 8'h81, "R7");
    // R4 reserved bits, R3 range, pin
    step(1, 8'hFD, 8'hF7, "R4");
    rd(8'hFD, "R4");
    // R11 undecoded writes and reads
    step(1, 8'hFA, 8'hFF, "R11");
    step(1, 8'hFE, 8'h00, "R11");
    rd(8'hFA, "R11"); rd(8'h00, "R11");
    // R9 clear, with writes during clear
    step(1, 8'hFC, 8'h0F, "R9");
    step(1, 8'hFD, 8'h01, "R9");
    step(1, 8'hFB, 8'h55, "R9");
    step(1, 8'hFC, 8'h07, "R9");
    rd(8'hFB, "R9"); rd(8'hFC, "R9");
    step(1, 8'hFD, 8'h03, "R9");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [7:0] a, d;
      r = $urandom % 16;
      d = 8'($urandom);
      if (r < 5)       a = 8'hFB;
      else if (r < 10) a = 8'hFC;
      else if (r < 12) begin
        a = 8'hFD;
        if (($urandom % 8) != 0) d[1] = 1'b1;
      end
      else if (r < 14) a = 8'($urandom);
      else             a = 8'hFB;
      if (r == 15) rd(8'($urandom % 4 + 8'hFA), "R10");
      else step(($urandom % 8) != 0, a, d, "R6");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule